// File: doc/BRIEF.md
# MDIO Indirect MMD Access Sequencer

This block gives a host access to extended-space (MMD) registers of a PHY over a management bus that carries only Clause 22 frames. The host presents a PHY address, a 5-bit device address, a 16-bit register number, a direction flag and, for writes, 16 bits of data. The block then issues four Clause 22 frames aimed at two fixed registers. Two frames go to the indirect control register and two go to the address/data register. When the last frame ends it raises a one-cycle done pulse and, for reads, presents the returned word.

The block contains its own bit-level bus master. MDC is derived from the system clock through a programmable half-period divider. MDIO is driven through a data/output-enable pair, and returned data is sampled on rising MDC edges. Only one access is in flight at a time. A request that arrives while the block is busy is dropped.

Top module: `mdio_mmd_access`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: One accepted request produces exactly four frames, in this order:
  - a write of Clause 22 register 0x0D with control word {2'b00, 9'b0, dev};
  - a write of register 0x0E with the register number;
  - a write of register 0x0D with {2'b01, 9'b0, dev};
  - a read or write of register 0x0E.
  In the control word, bits 15:14 hold the function (00 = address, 01 = data) and bits 4:0 hold the device address.
- R3: Every frame is 64 bits sent MSB first, in this order: 32 ones, start code 01, opcode (01 for write, 10 for read), 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits.
- R4: In a write frame the master drives MDIO (`mdio_oe` high) for all 64 bits, with turnaround 10 and the write data in the data field.
- R5: In the final read frame the master releases MDIO (`mdio_oe` low) for the 2 turnaround bits and the 16 data bits. It samples `mdio_i` on each rising MDC edge of the data field, MSB first, and presents the word on `rd_data` when `done` pulses.
- R6: `busy` rises on the clock after a request is accepted while idle. It stays high until the fourth frame ends. `done` is a one-cycle pulse in the same cycle that `busy` falls.
- R7: A request asserted while `busy` is high is ignored. The frames of the access in flight are unchanged, and no extra frames follow it.
- R8: MDC has a period of 2*(`mdc_half`+1) system clocks within a frame and is low whenever the block is idle.
- R9: `mdio_o` changes only while MDC is low, so every bit is stable across its rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_dev | input | 5 | MMD device address |
| req_reg | input | 16 | MMD register number |
| req_wdata | input | 16 | Write data |
| mdc_half | input | DIV_W | MDC half period minus one, in system clocks |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid at done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
Two situations are hard to reach from the ports. The first is a second request arriving in the middle of a frame. The bench reaches it by raising `req` with different parameters while a read access is partway through its frames, then confirms that the captured frames and read data belong only to the first access and that the bus stays quiet afterwards. The second is the read turnaround. A bus model in the bench counts MDC rising edges, and from that count it drives the turnaround and response bits only while the master has released the line, so a wrong release or sampling edge shows up as wrong read data or a wrong enable pattern.

// File: rtl/mdio_mmd_pkg.sv
package mdio_mmd_pkg;
    localparam logic [4:0] C22_CTRL_REG      = 5'h0D;
    localparam logic [4:0] C22_ADDR_DATA_REG = 5'h0E;
    localparam logic [1:0] FN_ADDRESS        = 2'b00;
    localparam logic [1:0] FN_DATA           = 2'b01;
    localparam logic [1:0] ST_CODE           = 2'b01;
    localparam logic [1:0] OPC_WRITE         = 2'b01;
    localparam logic [1:0] OPC_READ          = 2'b10;
    localparam logic [1:0] TA_DRIVE          = 2'b10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_e;

    function automatic logic [15:0] ctrl_word(input logic [1:0] fn, input logic [4:0] dev);
        return {fn, 9'd0, dev};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_cfg,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = en && (s_q.cnt == half_cfg);
        if (!en || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mdio_c22_frame.sv
module mdio_c22_frame
    import mdio_mmd_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd,
    input  logic [4:0]       phy,
    input  logic [4:0]       regad,
    input  logic [15:0]      wdata,
    input  logic [DIV_W-1:0] half_cfg,
    input  logic             mdio_i,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic [15:0]      rdata
);
    localparam int FRAME_LEN  = PRE_LEN + 32;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_START   = PRE_LEN + 14;
    localparam int DATA_START = PRE_LEN + 16;
    localparam logic [IDX_W-1:0] TA_IDX   = TA_START[IDX_W-1:0];
    localparam logic [IDX_W-1:0] DATA_IDX = DATA_START[IDX_W-1:0];
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 active;
        logic                 mdc;
        logic                 is_rd;
        logic                 dout;
        logic                 oe;
        logic                 done;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] shreg;
        logic [15:0]          rsh;
    } frm_st_t;

    frm_st_t s_d, s_q;
    logic    tick;
    logic [FRAME_LEN-1:0] frame_img;

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (s_q.active),
        .half_cfg (half_cfg),
        .tick     (tick)
    );

    always_comb begin
        frame_img = {{PRE_LEN{1'b1}}, ST_CODE, (rd ? OPC_READ : OPC_WRITE),
                     phy, regad, TA_DRIVE, (rd ? 16'd0 : wdata)};
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.mdc    = 1'b0;
                s_d.is_rd  = rd;
                s_d.idx    = '0;
                s_d.shreg  = frame_img;
                s_d.dout   = frame_img[FRAME_LEN-1];
                s_d.oe     = 1'b1;
                s_d.rsh    = '0;
            end
        end else if (tick) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;
                if (s_q.is_rd && (s_q.idx >= DATA_IDX)) begin
                    s_d.rsh = {s_q.rsh[14:0], mdio_i};
                end
            end else begin
                s_d.mdc = 1'b0;
                if (s_q.idx == LAST_IDX) begin
                    s_d.active = 1'b0;
                    s_d.oe     = 1'b0;
                    s_d.dout   = 1'b1;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.shreg = s_q.shreg << 1;
                    s_d.dout  = s_q.shreg[FRAME_LEN-2];
                    s_d.oe    = !(s_q.is_rd && (s_d.idx >= TA_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dout <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc     = s_q.mdc;
    assign mdio_o  = s_q.dout;
    assign mdio_oe = s_q.oe;
    assign done    = s_q.done;
    assign rdata   = s_q.rsh;
endmodule

// File: rtl/mdio_mmd_seq.sv
module mdio_mmd_seq
    import mdio_mmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_wr,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_dev,
    input  logic [15:0] req_reg,
    input  logic [15:0] req_wdata,
    input  logic        m_done,
    input  logic [15:0] m_rdata,
    output logic        m_start,
    output logic        m_rd,
    output logic [4:0]  m_phy,
    output logic [4:0]  m_reg,
    output logic [15:0] m_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data
);
    typedef struct packed {
        seq_state_e  st;
        logic [1:0]  step;
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  dev;
        logic [15:0] regnum;
        logic [15:0] wdata;
        logic        busy;
        logic        done;
        logic [15:0] rdata;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        m_phy   = s_q.phy;
        m_start = (s_q.st == SQ_ISSUE);
        m_rd    = 1'b0;
        unique case (s_q.step)
            2'd0: begin
                m_reg   = C22_CTRL_REG;
                m_wdata = ctrl_word(FN_ADDRESS, s_q.dev);
            end
            2'd1: begin
                m_reg   = C22_ADDR_DATA_REG;
                m_wdata = s_q.regnum;
            end
            2'd2: begin
                m_reg   = C22_CTRL_REG;
                m_wdata = ctrl_word(FN_DATA, s_q.dev);
            end
            default: begin
                m_reg   = C22_ADDR_DATA_REG;
                m_wdata = s_q.wdata;
                m_rd    = !s_q.wr;
            end
        endcase

        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (req) begin
                    s_d.st     = SQ_ISSUE;
                    s_d.step   = 2'd0;
                    s_d.wr     = req_wr;
                    s_d.phy    = req_phy;
                    s_d.dev    = req_dev;
                    s_d.regnum = req_reg;
                    s_d.wdata  = req_wdata;
                    s_d.busy   = 1'b1;
                end
            end
            SQ_ISSUE: begin
                s_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (m_done) begin
                    if (s_q.step == 2'd3) begin
                        s_d.st   = SQ_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        if (!s_q.wr) begin
                            s_d.rdata = m_rdata;
                        end
                    end else begin
                        s_d.step = s_q.step + 2'd1;
                        s_d.st   = SQ_ISSUE;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rd_data = s_q.rdata;
endmodule

// File: rtl/mdio_mmd_access.sv
module mdio_mmd_access #(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_dev,
    input  logic [15:0]      req_reg,
    input  logic [15:0]      req_wdata,
    input  logic [DIV_W-1:0] mdc_half,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic        m_start, m_rd, m_done;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_wdata, m_rdata;

    mdio_mmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_phy   (req_phy),
        .req_dev   (req_dev),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .m_done    (m_done),
        .m_rdata   (m_rdata),
        .m_start   (m_start),
        .m_rd      (m_rd),
        .m_phy     (m_phy),
        .m_reg     (m_reg),
        .m_wdata   (m_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data)
    );

    mdio_c22_frame #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (m_start),
        .rd       (m_rd),
        .phy      (m_phy),
        .regad    (m_reg),
        .wdata    (m_wdata),
        .half_cfg (mdc_half),
        .mdio_i   (mdio_i),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (m_done),
        .rdata    (m_rdata)
    );
endmodule

// File: rtl/mdio_mmd_checker.sv
module mdio_mmd_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R8
    AST_REQ_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R6
    AST_MDIO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc); // R9
endmodule

bind mdio_mmd_access mdio_mmd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_mmd_access_bench.sv
module mdio_mmd_access_bench;
    typedef struct packed {
        logic [7:0]  div;
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  dev;
        logic [15:0] regn;
        logic [15:0] wdata;
        logic [15:0] resp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'd3, 1'b1, 5'h01, 5'h1F, 16'h0000, 16'hA5A5, 16'h0000},
        '{8'd3, 1'b0, 5'h1F, 5'h07, 16'hFFFF, 16'h0000, 16'h8001},
        '{8'd0, 1'b1, 5'h00, 5'h00, 16'h1234, 16'hFFFF, 16'h0000},
        '{8'd1, 1'b0, 5'h10, 5'h1E, 16'h8000, 16'h0000, 16'h5A3C},
        '{8'd2, 1'b0, 5'h0A, 5'h03, 16'h0001, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  mdc_half = 8'd0;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int bit_cnt = 0;
    int frame_n = 0;
    int last_rise = 0;
    int mdc_period = 0;
    logic [63:0] cap_q = '0;
    logic [63:0] capoe_q = '0;
    logic [63:0] frames [0:15];
    logic [63:0] oes [0:15];
    logic [15:0] phy_resp = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_mmd_access u_mdio_mmd_access (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_phy(req_phy),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .mdc_half(mdc_half), .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // bus model: turnaround second bit driven low, data MSB first
    assign mdio_i = (bit_cnt >= 48) ? phy_resp[63 - bit_cnt] : (bit_cnt != 47);

    always @(posedge mdc) begin : cap_blk
        logic ln;
        logic [63:0] nc, no;
        ln = mdio_oe ? mdio_o : mdio_i;
        nc = {cap_q[62:0], ln};
        no = {capoe_q[62:0], mdio_oe};
        cap_q   <= nc;
        capoe_q <= no;
        if (bit_cnt != 0) mdc_period <= cyc - last_rise;
        last_rise <= cyc;
        if (bit_cnt == 63) begin
            frames[frame_n % 16] <= nc;
            oes[frame_n % 16]    <= no;
            frame_n <= frame_n + 1;
            bit_cnt <= 0;
        end else begin
            bit_cnt <= bit_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
    endfunction

    task automatic run_access(input vec_t v, input bit inject, input vec_t w);
        int base;
        int waited;
        logic [63:0] exp_f [0:3];
        logic [63:0] exp_oe;
        base = frame_n;
        mdc_half = v.div;
        phy_resp = v.resp;
        @(negedge clk);
        req = 1'b1; req_wr = v.wr; req_phy = v.phy; req_dev = v.dev;
        req_reg = v.regn; req_wdata = v.wdata;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R6 busy after accept", {63'd0, busy}, 64'd1);
        if (inject) begin
            repeat (300) @(negedge clk);
            req = 1'b1; req_wr = w.wr; req_phy = w.phy; req_dev = w.dev;
            req_reg = w.regn; req_wdata = w.wdata;
            @(negedge clk);
            req = 1'b0;
        end
        waited = 0;
        while (!done && waited < 50000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R6 done seen", {63'd0, done}, 64'd1);
        chk(busy == 1'b0, "R6 busy low at done", {63'd0, busy}, 64'd0);
        if (!v.wr) chk(rd_data == v.resp, "R5 read data", {48'd0, rd_data}, {48'd0, v.resp});
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", {63'd0, done}, 64'd0);
        chk(frame_n - base == 4, "R2 frame count", 64'(frame_n - base), 64'd4);
        exp_f[0] = mk(1'b0, v.phy, 5'h0D, {2'b00, 9'd0, v.dev});
        exp_f[1] = mk(1'b0, v.phy, 5'h0E, v.regn);
        exp_f[2] = mk(1'b0, v.phy, 5'h0D, {2'b01, 9'd0, v.dev});
        exp_f[3] = mk(!v.wr, v.phy, 5'h0E, v.wr ? v.wdata : v.resp);
        for (int k = 0; k < 4; k++) begin
            chk(frames[(base + k) % 16] == exp_f[k], "R2 R3 frame bits",
                frames[(base + k) % 16], exp_f[k]);
            exp_oe = (k == 3 && !v.wr) ? ~64'h3FFFF : ~64'd0;
            chk(oes[(base + k) % 16] == exp_oe, (k == 3 && !v.wr) ? "R5 release" : "R4 drive",
                oes[(base + k) % 16], exp_oe);
        end
        chk(mdc_period == 2 * (int'(v.div) + 1), "R8 mdc period",
            64'(mdc_period), 64'(2 * (int'(v.div) + 1)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mdc && !mdio_oe, "R1 reset outputs",
            {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R1 idle after reset",
            {61'd0, busy, mdc, mdio_oe}, 64'd0);

        for (int i = 0; i < NV; i++) run_access(VEC[i], 1'b0, VEC[i]);

        // R7 request while busy is ignored
        run_access(VEC[1], 1'b1, VEC[2]);
        begin
            int fn0;
            fn0 = frame_n;
            repeat (2000) @(negedge clk);
            chk(frame_n == fn0 && !busy && !mdc, "R7 no extra frames",
                64'(frame_n - fn0), 64'd0);
        end

        // R9 spot check on a write with alternating data
        run_access('{8'd5, 1'b1, 5'h15, 5'h0A, 16'h5555, 16'hAAAA, 16'h0000}, 1'b0, VEC[0]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule